// File: doc/BRIEF.md
# Streaming Instruction Word Decoder with Address Tracking

The block accepts a stream of 32-bit machine instruction words over a valid/ready handshake. It assigns each accepted word its byte address and emits one registered record per word. The record holds the word's address, its format class (register, immediate or jump), every field of that format, the sign-extended 16-bit immediate, and a resolved absolute target for branches and jumps. It also carries a compact operation tag for six supported operations (or, slt, add, addi, beq, j) and a flag for words outside that subset. Downstream tooling, such as trace annotators, branch-target prefetchers or static analysers, can consume the record directly, without re-deriving program-counter arithmetic.

The address counter starts at 0x00400000 after reset and moves up by 4 for every accepted word. A synchronous load port can redirect it at any time. The output stage is a small state machine with two states. In `S_EMPTY` the output register holds nothing. In `S_FULL` it holds a record. The transitions are T_FILL (`S_EMPTY` to `S_FULL` on an accepted word), T_DRAIN (`S_FULL` to `S_EMPTY` when the record is taken and no word arrives), T_REPLACE (`S_FULL` to `S_FULL` when the record is taken and a new word is accepted in the same cycle) and T_STALL (`S_FULL` to `S_FULL` while downstream is not ready). Input ready mirrors output ready, so backpressure stalls both the record and the address counter.

Top module: `idec_stream`

## Requirements
- R1: The format code is 0 (register format) when bits [31:26] equal 0, 2 (jump format) when they equal 2 or 3, and 1 (immediate format) for every other value.
- R2: The fields are reported at fixed bit positions regardless of format: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], funct [5:0], and a 26-bit jump index [25:0].
- R3: The 32-bit immediate output is bits [15:0] sign-extended, so a low half of 0xFFFF reads as 0xFFFFFFFF.
- R4: After reset, the first accepted word has address 0x00400000. Each further accepted word is 4 higher. Cycles without acceptance do not move the address.
- R5: For opcodes 4 and 5, the target is the word's address plus 4 plus the sign-extended immediate times 4, and the has-target flag is 1.
- R6: For opcodes 2 and 3, the target is bits [31:28] of (address + 4), followed by the 26-bit index, followed by two zero bits, and the has-target flag is 1. For any other opcode, both the target and the flag are 0.
- R7: The operation tag is 1 for or (opcode 0, funct 37), 2 for slt (opcode 0, funct 42), 3 for add (opcode 0, funct 32), 4 for addi (opcode 8), 5 for beq (opcode 4), 6 for j (opcode 2), and 0 otherwise.
- R8: The unknown flag is 1 exactly when the operation tag is 0. Format and fields are still reported for such words.
- R9: When load is high in a cycle, the next accepted word (including one accepted in that same cycle) gets the load address. Later words continue from there in steps of 4.
- R10: Input ready equals output ready. Each accepted word appears at the output on the next clock edge. While output valid is high and output ready is low, the record stays unchanged.
- R11: During reset and on its release, output valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_word | input | 32 | Instruction word |
| load_en | input | 1 | Redirect the tracked address |
| load_addr | input | 32 | New byte address |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Downstream takes the record |
| out_pc | output | 32 | Byte address of the word |
| out_fmt | output | 2 | Format code (0 reg, 1 imm, 2 jump) |
| out_opcode | output | 6 | Bits [31:26] |
| out_rs | output | 5 | Bits [25:21] |
| out_rt | output | 5 | Bits [20:16] |
| out_rd | output | 5 | Bits [15:11] |
| out_shamt | output | 5 | Bits [10:6] |
| out_funct | output | 6 | Bits [5:0] |
| out_simm | output | 32 | Sign-extended immediate |
| out_jidx | output | 26 | Bits [25:0] |
| out_target | output | 32 | Resolved absolute target |
| out_has_target | output | 1 | Target is meaningful |
| out_op | output | 3 | Operation tag |
| out_unknown | output | 1 | Word is outside the supported subset |

## Verification
The fixed six-word program, run from the reset address, separates the three format classes. It checks a forward branch and a jump back into the same region against known targets, and a negative immediate against known values. Directed words with opcode 3, opcode 5 and a zero register-format word test that an unknown flag does not suppress target resolution or field reporting. A load to 0x1FFFFFF8 places a jump so that address + 4 crosses a 256 MiB boundary, which tells the upper bits of the next address apart from those of the current one. Random words, mixing supported encodings with random fields and random opcodes, run under random backpressure and random loads, some of them coinciding with an accepted word. This shows whether stalls freeze the address and record, and whether a load takes effect for the same-cycle word.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned OPC_W      = 6;
    localparam int unsigned REG_W      = 5;
    localparam int unsigned IMM_W      = 16;
    localparam int unsigned JIDX_W     = 26;
    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned ALIGN_W    = 2;
    localparam int unsigned REGION_W   = WORD_W - JIDX_W - ALIGN_W;
    localparam int unsigned EXT_W      = WORD_W - IMM_W;

    typedef enum logic [1:0] {
        FMT_R = 2'd0,
        FMT_I = 2'd1,
        FMT_J = 2'd2
    } fmt_e;

    typedef enum logic [2:0] {
        OP_UNK  = 3'd0,
        OP_OR   = 3'd1,
        OP_SLT  = 3'd2,
        OP_ADD  = 3'd3,
        OP_ADDI = 3'd4,
        OP_BEQ  = 3'd5,
        OP_J    = 3'd6
    } op_e;

    localparam logic [OPC_W-1:0] OPC_REG  = 6'd0;
    localparam logic [OPC_W-1:0] OPC_JMP  = 6'd2;
    localparam logic [OPC_W-1:0] OPC_JLNK = 6'd3;
    localparam logic [OPC_W-1:0] OPC_BEQ  = 6'd4;
    localparam logic [OPC_W-1:0] OPC_BNE  = 6'd5;
    localparam logic [OPC_W-1:0] OPC_ADDI = 6'd8;

    localparam logic [OPC_W-1:0] FN_ADD = 6'd32;
    localparam logic [OPC_W-1:0] FN_OR  = 6'd37;
    localparam logic [OPC_W-1:0] FN_SLT = 6'd42;

    typedef struct packed {
        logic [WORD_W-1:0] pc;
        fmt_e              fmt;
        logic [OPC_W-1:0]  opcode;
        logic [REG_W-1:0]  rs;
        logic [REG_W-1:0]  rt;
        logic [REG_W-1:0]  rd;
        logic [REG_W-1:0]  shamt;
        logic [OPC_W-1:0]  funct;
        logic [WORD_W-1:0] simm;
        logic [JIDX_W-1:0] jidx;
        logic [WORD_W-1:0] target;
        logic              has_target;
        op_e               op;
        logic              unknown;
    } rec_t;

endpackage

// File: rtl/idec_fields.sv
module idec_fields
    import idec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fmt_e              fmt,
    output logic [OPC_W-1:0]  opcode,
    output logic [REG_W-1:0]  rs,
    output logic [REG_W-1:0]  rt,
    output logic [REG_W-1:0]  rd,
    output logic [REG_W-1:0]  shamt,
    output logic [OPC_W-1:0]  funct,
    output logic [WORD_W-1:0] simm,
    output logic [JIDX_W-1:0] jidx,
    output op_e               op,
    output logic              unknown
);

    localparam int unsigned OPC_LSB = WORD_W - OPC_W;
    localparam int unsigned RS_LSB  = OPC_LSB - REG_W;
    localparam int unsigned RT_LSB  = RS_LSB - REG_W;
    localparam int unsigned RD_LSB  = RT_LSB - REG_W;
    localparam int unsigned SH_LSB  = RD_LSB - REG_W;

    always_comb begin
        opcode = word[WORD_W-1:OPC_LSB];
        rs     = word[OPC_LSB-1:RS_LSB];
        rt     = word[RS_LSB-1:RT_LSB];
        rd     = word[RT_LSB-1:RD_LSB];
        shamt  = word[RD_LSB-1:SH_LSB];
        funct  = word[SH_LSB-1:0];
        jidx   = word[JIDX_W-1:0];
        simm   = {{EXT_W{word[IMM_W-1]}}, word[IMM_W-1:0]};
    end

    always_comb begin
        unique case (opcode)
            OPC_REG:           fmt = FMT_R;
            OPC_JMP, OPC_JLNK: fmt = FMT_J;
            default:           fmt = FMT_I;
        endcase
    end

    always_comb begin
        op = OP_UNK;
        unique case (opcode)
            OPC_REG: begin
                unique case (funct)
                    FN_OR:   op = OP_OR;
                    FN_SLT:  op = OP_SLT;
                    FN_ADD:  op = OP_ADD;
                    default: op = OP_UNK;
                endcase
            end
            OPC_ADDI: op = OP_ADDI;
            OPC_BEQ:  op = OP_BEQ;
            OPC_JMP:  op = OP_J;
            default:  op = OP_UNK;
        endcase
        unknown = (op == OP_UNK);
    end

endmodule

// File: rtl/idec_target.sv
module idec_target
    import idec_pkg::*;
(
    input  logic [WORD_W-1:0] pc,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [WORD_W-1:0] simm,
    input  logic [JIDX_W-1:0] jidx,
    output logic [WORD_W-1:0] target,
    output logic              has_target
);

    typedef enum logic [1:0] {
        TK_NONE   = 2'd0,
        TK_BRANCH = 2'd1,
        TK_JUMP   = 2'd2
    } tkind_e;

    tkind_e            kind;
    logic [WORD_W-1:0] seq_pc;
    logic [WORD_W-1:0] br_tgt;
    logic [WORD_W-1:0] jp_tgt;

    always_comb begin
        unique case (opcode)
            OPC_BEQ, OPC_BNE:  kind = TK_BRANCH;
            OPC_JMP, OPC_JLNK: kind = TK_JUMP;
            default:           kind = TK_NONE;
        endcase
    end

    always_comb begin
        seq_pc = pc + WORD_W'(WORD_BYTES);
        br_tgt = seq_pc + {simm[WORD_W-ALIGN_W-1:0], {ALIGN_W{1'b0}}};
        jp_tgt = {seq_pc[WORD_W-1 -: REGION_W], jidx, {ALIGN_W{1'b0}}};
    end

    always_comb begin
        unique case (kind)
            TK_BRANCH: begin target = br_tgt; has_target = 1'b1; end
            TK_JUMP:   begin target = jp_tgt; has_target = 1'b1; end
            default:   begin target = '0;     has_target = 1'b0; end
        endcase
    end

endmodule

// File: rtl/idec_pc.sv
module idec_pc
    import idec_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_PC = 32'h0040_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_addr,
    output logic [WORD_W-1:0] cur_pc
);

    logic [WORD_W-1:0] pc_q;

    assign cur_pc = load_en ? load_addr : pc_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       pc_q <= RESET_PC;
        else if (fire)    pc_q <= cur_pc + WORD_W'(WORD_BYTES);
        else if (load_en) pc_q <= load_addr;
    end

    // R4: accepted words advance the address by one word
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !load_en) |=> (pc_q == $past(pc_q) + WORD_W'(WORD_BYTES)));

    // R4: no acceptance and no load leaves the address alone
    a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !load_en) |=> $stable(pc_q));

    // R9: a load with an accepted word continues one word past the load address
    a_r9_load_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && load_en) |=> (pc_q == $past(load_addr) + WORD_W'(WORD_BYTES)));

endmodule

// File: rtl/idec_stream.sv
module idec_stream
    import idec_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_word,
    input  logic        load_en,
    input  logic [31:0] load_addr,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_pc,
    output logic [1:0]  out_fmt,
    output logic [5:0]  out_opcode,
    output logic [4:0]  out_rs,
    output logic [4:0]  out_rt,
    output logic [4:0]  out_rd,
    output logic [4:0]  out_shamt,
    output logic [5:0]  out_funct,
    output logic [31:0] out_simm,
    output logic [25:0] out_jidx,
    output logic [31:0] out_target,
    output logic        out_has_target,
    output logic [2:0]  out_op,
    output logic        out_unknown
);

    typedef enum logic {
        S_EMPTY = 1'b0,
        S_FULL  = 1'b1
    } state_e;

    state_e state_q, state_d;
    logic   fire;
    rec_t   rec_d, rec_q;

    logic [WORD_W-1:0] cur_pc;

    assign in_ready = out_ready;
    assign fire     = in_valid && out_ready;

    idec_pc #(.RESET_PC(RESET_PC)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .load_en   (load_en),
        .load_addr (load_addr),
        .cur_pc    (cur_pc)
    );

    idec_fields u_fields (
        .word    (in_word),
        .fmt     (rec_d.fmt),
        .opcode  (rec_d.opcode),
        .rs      (rec_d.rs),
        .rt      (rec_d.rt),
        .rd      (rec_d.rd),
        .shamt   (rec_d.shamt),
        .funct   (rec_d.funct),
        .simm    (rec_d.simm),
        .jidx    (rec_d.jidx),
        .op      (rec_d.op),
        .unknown (rec_d.unknown)
    );

    idec_target u_target (
        .pc         (cur_pc),
        .opcode     (rec_d.opcode),
        .simm       (rec_d.simm),
        .jidx       (rec_d.jidx),
        .target     (rec_d.target),
        .has_target (rec_d.has_target)
    );

    assign rec_d.pc = cur_pc;

    // next-state logic: T_FILL, T_DRAIN, T_REPLACE, T_STALL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_EMPTY: if (fire)      state_d = S_FULL;
            S_FULL:  if (out_ready) state_d = in_valid ? S_FULL : S_EMPTY;
            default:                state_d = S_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    rec_q <= '0;
        else if (fire) rec_q <= rec_d;
    end

    always_comb begin
        out_valid      = (state_q == S_FULL);
        out_pc         = rec_q.pc;
        out_fmt        = rec_q.fmt;
        out_opcode     = rec_q.opcode;
        out_rs         = rec_q.rs;
        out_rt         = rec_q.rt;
        out_rd         = rec_q.rd;
        out_shamt      = rec_q.shamt;
        out_funct      = rec_q.funct;
        out_simm       = rec_q.simm;
        out_jidx       = rec_q.jidx;
        out_target     = rec_q.target;
        out_has_target = rec_q.has_target;
        out_op         = rec_q.op;
        out_unknown    = rec_q.unknown;
    end

    // R10: a stalled record stays in place
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pc) && $stable(out_opcode)
                                       && $stable(out_target) && $stable(out_simm)));

    // R10: an accepted word is visible on the next edge
    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R1: register format only for opcode zero
    a_r1_reg_fmt: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fmt == FMT_R) |-> (out_opcode == OPC_REG));

    // R3: upper half of the immediate copies its sign bit
    a_r3_sext: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_simm[WORD_W-1:IMM_W] == {EXT_W{out_simm[IMM_W-1]}}));

    // R6: jump-format records always carry a word-aligned target
    a_r6_jump_tgt: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fmt == FMT_J) |-> (out_has_target && out_target[ALIGN_W-1:0] == '0));

    // R8: a tagged operation is never flagged unknown
    a_r8_tag_known: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_op != OP_UNK) |-> !out_unknown);

    // R11: no record right after reset
    a_r11_reset_empty: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

// File: tb/idec_stream_tb.sv
`timescale 1ns/1ps
module idec_stream_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_ready, load_en, out_valid, out_ready;
    logic [31:0] in_word, load_addr, out_pc, out_simm, out_target;
    logic [1:0]  out_fmt;
    logic [5:0]  out_opcode, out_funct;
    logic [4:0]  out_rs, out_rt, out_rd, out_shamt;
    logic [25:0] out_jidx;
    logic        out_has_target, out_unknown;
    logic [2:0]  out_op;

    always #2.5 clk = ~clk;

    idec_stream u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .load_en(load_en), .load_addr(load_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc),
        .out_fmt(out_fmt), .out_opcode(out_opcode), .out_rs(out_rs),
        .out_rt(out_rt), .out_rd(out_rd), .out_shamt(out_shamt),
        .out_funct(out_funct), .out_simm(out_simm), .out_jidx(out_jidx),
        .out_target(out_target), .out_has_target(out_has_target),
        .out_op(out_op), .out_unknown(out_unknown)
    );

    typedef struct packed {
        logic [31:0] pc;
        logic [1:0]  fmt;
        logic [31:0] word;
        logic [31:0] simm;
        logic [31:0] tgt;
        logic        has;
        logic [2:0]  op;
    } exp_t;

    exp_t        exp_q[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic [31:0] mpc;
    int          nout = 0;
    logic [2:0]  cap_op[0:7];
    logic [31:0] cap_tgt[0:7];
    logic [31:0] cap_simm[0:7];
    logic [31:0] cap_pc[0:7];
    bit          hold_pend = 1'b0;
    logic [31:0] hold_pc, hold_tgt;

    function automatic exp_t model(logic [31:0] pc, logic [31:0] w);
        exp_t        e;
        logic [5:0]  opc;
        logic [31:0] nxt;
        opc    = w[31:26];
        nxt    = pc + 32'd4;
        e.pc   = pc;
        e.word = w;
        e.simm = w[15] ? {16'hFFFF, w[15:0]} : {16'h0000, w[15:0]};
        if (opc == 6'd0)                    e.fmt = 2'd0;
        else if (opc == 6'd2 || opc == 6'd3) e.fmt = 2'd2;
        else                                e.fmt = 2'd1;
        e.has = 1'b0;
        e.tgt = 32'd0;
        if (opc == 6'd4 || opc == 6'd5) begin
            e.has = 1'b1;
            e.tgt = nxt + e.simm * 32'd4;
        end else if (opc == 6'd2 || opc == 6'd3) begin
            e.has = 1'b1;
            e.tgt = (nxt & 32'hF000_0000) | ({6'd0, w[25:0]} << 2);
        end
        e.op = 3'd0;
        if (opc == 6'd0 && w[5:0] == 6'd37) e.op = 3'd1;
        if (opc == 6'd0 && w[5:0] == 6'd42) e.op = 3'd2;
        if (opc == 6'd0 && w[5:0] == 6'd32) e.op = 3'd3;
        if (opc == 6'd8) e.op = 3'd4;
        if (opc == 6'd4) e.op = 3'd5;
        if (opc == 6'd2) e.op = 3'd6;
        return e;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic compare_out();
        exp_t e;
        if (exp_q.size() == 0) begin
            chk("R10 unexpected record", 32'd1, 32'd0);
            return;
        end
        e = exp_q.pop_front();
        chk("R4/R9 address", out_pc, e.pc);
        chk("R1 format", {30'd0, out_fmt}, {30'd0, e.fmt});
        chk("R2 opcode", {26'd0, out_opcode}, {26'd0, e.word[31:26]});
        chk("R2 regs", {17'd0, out_rs, out_rt, out_rd}, {17'd0, e.word[25:11]});
        chk("R2 shamt/funct", {21'd0, out_shamt, out_funct}, {21'd0, e.word[10:0]});
        chk("R2 jidx", {6'd0, out_jidx}, {6'd0, e.word[25:0]});
        chk("R3 simm", out_simm, e.simm);
        chk("R5/R6 target", out_target, e.tgt);
        chk("R5/R6 has_target", {31'd0, out_has_target}, {31'd0, e.has});
        chk("R7 op", {29'd0, out_op}, {29'd0, e.op});
        chk("R8 unknown", {31'd0, out_unknown}, {31'd0, (e.op == 3'd0)});
        if (nout < 8) begin
            cap_op[nout]   = out_op;
            cap_tgt[nout]  = out_target;
            cap_simm[nout] = out_simm;
            cap_pc[nout]   = out_pc;
        end
        nout++;
    endtask

    task automatic step(bit iv, logic [31:0] w, bit ordy, bit ld, logic [31:0] la);
        logic [31:0] cur;
        @(negedge clk);
        if (hold_pend) begin
            chk("R10 hold valid", {31'd0, out_valid}, 32'd1);
            chk("R10 hold pc", out_pc, hold_pc);
            chk("R10 hold target", out_target, hold_tgt);
        end
        in_valid  = iv;
        in_word   = w;
        out_ready = ordy;
        load_en   = ld;
        load_addr = la;
        #1;
        hold_pend = 1'b0;
        if (out_valid && !out_ready) begin
            hold_pend = 1'b1;
            hold_pc   = out_pc;
            hold_tgt  = out_target;
        end
        if (out_valid && out_ready) compare_out();
        cur = ld ? la : mpc;
        if (iv && in_ready) begin
            exp_q.push_back(model(cur, w));
            mpc = cur + 32'd4;
        end else if (ld) begin
            mpc = la;
        end
    endtask

    function automatic logic [31:0] rand_word();
        logic [31:0] w;
        int          sel;
        w   = $urandom;
        sel = $urandom % 4;
        if (sel == 1) begin
            w[31:26] = 6'd0;
            case ($urandom % 4)
                0: w[5:0] = 6'd32;
                1: w[5:0] = 6'd37;
                2: w[5:0] = 6'd42;
                default: ;
            endcase
        end else if (sel == 2) begin
            case ($urandom % 5)
                0: w[31:26] = 6'd4;
                1: w[31:26] = 6'd5;
                2: w[31:26] = 6'd8;
                3: w[31:26] = 6'd2;
                default: w[31:26] = 6'd3;
            endcase
        end
        return w;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] prog [0:5];
        void'($urandom(32'h5EED_1234));
        prog[0] = 32'h0000_1025; prog[1] = 32'h0005_402A; prog[2] = 32'h1100_0003;
        prog[3] = 32'h0044_1020; prog[4] = 32'h20A5_FFFF; prog[5] = 32'h0810_0001;
        rst_n = 1'b0; in_valid = 1'b0; in_word = '0; out_ready = 1'b0;
        load_en = 1'b0; load_addr = '0;
        mpc = 32'h0040_0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 valid in reset", {31'd0, out_valid}, 32'd0);
        out_ready = 1'b1; #1;
        chk("R10 ready follows", {31'd0, in_ready}, 32'd1);
        out_ready = 1'b0; #1;
        chk("R10 ready follows low", {31'd0, in_ready}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 valid after release", {31'd0, out_valid}, 32'd0);

        // directed six-word program from the reset address
        for (int i = 0; i < 6; i++) step(1'b1, prog[i], 1'b1, 1'b0, '0);
        step(1'b0, '0, 1'b1, 1'b0, '0);
        chk("R7 or",   {29'd0, cap_op[0]}, 32'd1);
        chk("R7 slt",  {29'd0, cap_op[1]}, 32'd2);
        chk("R7 beq",  {29'd0, cap_op[2]}, 32'd5);
        chk("R7 add",  {29'd0, cap_op[3]}, 32'd3);
        chk("R7 addi", {29'd0, cap_op[4]}, 32'd4);
        chk("R7 j",    {29'd0, cap_op[5]}, 32'd6);
        chk("R4 first address", cap_pc[0], 32'h0040_0000);
        chk("R4 sixth address", cap_pc[5], 32'h0040_0014);
        chk("R5 beq target", cap_tgt[2], 32'h0040_0018);
        chk("R6 j target", cap_tgt[5], 32'h0040_0004);
        chk("R3 minus one", cap_simm[4], 32'hFFFF_FFFF);

        // backpressure: offered words are not taken, record held
        step(1'b1, 32'h2002_0005, 1'b1, 1'b0, '0);
        step(1'b1, 32'h1111_1111, 1'b0, 1'b0, '0);
        step(1'b1, 32'h2222_2222, 1'b0, 1'b0, '0);
        step(1'b1, 32'h3333_3333, 1'b0, 1'b0, '0);
        step(1'b1, 32'h0800_0000, 1'b1, 1'b0, '0);

        // load with same-cycle word, then a region crossing jump
        step(1'b1, 32'h1400_FFFE, 1'b1, 1'b1, 32'h1FFF_FFF8);
        step(1'b1, 32'h0C00_0010, 1'b1, 1'b0, '0);
        // load alone, then unknown words
        step(1'b0, '0, 1'b1, 1'b1, 32'h0000_1000);
        step(1'b1, 32'h0000_0000, 1'b1, 1'b0, '0);
        step(1'b1, 32'h0C00_0001, 1'b1, 1'b0, '0);
        step(1'b1, 32'h1400_0001, 1'b1, 1'b0, '0);
        step(1'b0, '0, 1'b1, 1'b0, '0);
        chk("R9 load address used", out_pc, 32'h0000_1008);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            bit          iv, rdy, ld;
            logic [31:0] la;
            iv  = ($urandom % 4) != 0;
            rdy = ($urandom % 4) != 0;
            ld  = ($urandom % 32) == 0;
            la  = {$urandom, 2'b00} >> 0;
            la[1:0] = 2'b00;
            step(iv, rand_word(), rdy, ld, la);
        end
        for (int n = 0; n < 4; n++) step(1'b0, '0, 1'b1, 1'b0, '0);
        chk("R10 all records delivered", exp_q.size(), 32'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule